// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address into a 34-bit physical address using a two-level radix tree of page table entries kept in memory. A requester presents an address, an access kind (read, write or instruction fetch) and the current value of the translation root register. The walker reads one entry per level over a word-wide memory request/response port. It then returns either a physical address or a page fault, as a single-cycle result pulse.

A leaf entry may sit at the second level and map a 4 KiB page, or at the first level and map a 4 MiB superpage. An entry whose read, write and execute bits are all clear points to the next table. When the root register disables translation, the address passes through unchanged and no memory is touched. The block accepts one translation at a time and keeps no cache of earlier walks.

Top module: `pt_walker`

## Requirements
- R1: When root bit 31 is 0, the result is the virtual address zero-extended to 34 bits, with no fault and no memory request.
- R2: The first entry is read at {root[21:0], va[31:22], 2'b00}. A pointer entry leads to the second read at {pte[31:10], va[21:12], 2'b00}. Root bits 30:22 (address-space tag) have no effect on the result.
- R3: An entry with its valid bit (bit 0) clear, at either level, produces a fault.
- R4: An entry with write (bit 2) set and read (bit 1) clear produces a fault.
- R5: A pointer entry (bits 3:1 all zero) found at the second level produces a fault.
- R6: Access kind 2'b00 (read) needs bit 1, 2'b01 (write) needs bit 2, and 2'b10 (fetch) needs bit 3 of the leaf. Kind 2'b11 always faults. A missing permission faults.
- R7: A valid second-level leaf yields {pte[31:10], va[11:0]}.
- R8: A valid first-level leaf with pte[19:10] zero yields {pte[31:20], va[21:0]}. A nonzero pte[19:10] faults.
- R9: mem_req_valid and mem_req_addr hold steady until mem_req_ready. Only one read is outstanding at a time.
- R10: rsp_valid is high for exactly one cycle per accepted request, and rsp_paddr is 0 when rsp_fault is 1.
- R11: After reset, req_ready is 1 and mem_req_valid and rsp_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 00 read, 01 write, 10 fetch |
| root | input | 32 | Root register: enable, address-space tag, root page number |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 34 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Entry word |
| rsp_valid | output | 1 | Result pulse |
| rsp_paddr | output | 34 | Physical address |
| rsp_fault | output | 1 | Page fault |

## Verification
The bench sweeps every first-level entry kind against every second-level permission nibble and every access kind. This covers the write-without-read encoding, an invalid pointer, a pointer at the bottom level, and aligned and misaligned superpages. A walker that mis-ordered its checks would translate an illegal entry. A walker that took a pointer as a leaf would return a bogus address. One that dropped the superpage alignment test would mix stray page-number bits into the offset. The address-space tag and the memory stall pattern vary from walk to walk, and each walk's entry addresses are compared. Bare-mode requests confirm that no memory read is issued.

// File: rtl/pt_walker.sv
module pt_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_vaddr,
  input  logic [1:0]  req_kind,
  input  logic [31:0] root,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [33:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  output logic        rsp_valid,
  output logic [33:0] rsp_paddr,
  output logic        rsp_fault
);
  typedef enum logic [2:0] {S_IDLE, S_REQ1, S_WAIT1, S_REQ2, S_WAIT2, S_DONE} st_t;
  st_t st;
  logic [31:0] va_q;
  logic [1:0]  kind_q;
  logic [33:0] addr_q, pa_q;
  logic        flt_q;

  wire e_v = mem_rsp_data[0];
  wire e_r = mem_rsp_data[1];
  wire e_w = mem_rsp_data[2];
  wire e_x = mem_rsp_data[3];
  wire is_ptr  = !e_r && !e_w && !e_x;
  wire bad_enc = !e_v || (e_w && !e_r);
  wire perm_ok = (kind_q == 2'b00) ? e_r :
                 (kind_q == 2'b01) ? e_w :
                 (kind_q == 2'b10) ? e_x : 1'b0;
  wire mis_sp  = |mem_rsp_data[19:10];

  logic unused_bits;
  assign unused_bits = ^{mem_rsp_data[9:4], root[30:22]};

  assign req_ready     = (st == S_IDLE);
  assign mem_req_valid = (st == S_REQ1) || (st == S_REQ2);
  assign mem_req_addr  = addr_q;
  assign rsp_valid     = (st == S_DONE);
  assign rsp_paddr     = pa_q;
  assign rsp_fault     = flt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; va_q <= '0; kind_q <= '0;
      addr_q <= '0; pa_q <= '0; flt_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va_q   <= req_vaddr;
          kind_q <= req_kind;
          flt_q  <= 1'b0;
          if (root[31]) begin
            addr_q <= {root[21:0], req_vaddr[31:22], 2'b00};
            st     <= S_REQ1;
          end else begin
            pa_q <= {2'b00, req_vaddr};
            st   <= S_DONE;
          end
        end
        S_REQ1: if (mem_req_ready) st <= S_WAIT1;
        S_REQ2: if (mem_req_ready) st <= S_WAIT2;
        S_WAIT1: if (mem_rsp_valid) begin
          if (bad_enc) begin
            flt_q <= 1'b1; pa_q <= '0; st <= S_DONE;
          end else if (is_ptr) begin
            addr_q <= {mem_rsp_data[31:10], va_q[21:12], 2'b00};
            st     <= S_REQ2;
          end else if (!perm_ok || mis_sp) begin
            flt_q <= 1'b1; pa_q <= '0; st <= S_DONE;
          end else begin
            pa_q <= {mem_rsp_data[31:20], va_q[21:0]};
            st   <= S_DONE;
          end
        end
        S_WAIT2: if (mem_rsp_valid) begin
          if (bad_enc || is_ptr || !perm_ok) begin
            flt_q <= 1'b1; pa_q <= '0;
          end else begin
            pa_q <= {mem_rsp_data[31:10], va_q[11:0]};
          end
          st <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1
  bare_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !root[31] |=>
      rsp_valid && !rsp_fault && rsp_paddr == {2'b00, $past(req_vaddr)});
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  // R9
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);
  // R10
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R10
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_paddr == 34'd0);
  // R7
  offset_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_paddr[11:0] == va_q[11:0]);
endmodule

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [31:0] req_vaddr = 0, root = 0;
  logic [1:0] req_kind = 0;
  logic mem_req_valid, mem_req_ready = 0, mem_rsp_valid = 0;
  logic [33:0] mem_req_addr;
  logic [31:0] mem_rsp_data = 0;
  logic rsp_valid, rsp_fault;
  logic [33:0] rsp_paddr;

  always #10 clk = ~clk;

  pt_walker u0 (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_kind(req_kind), .root(root),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault));

  int total = 0, bad = 0, cyc = 0;
  logic [31:0] pmem [logic [33:0]];
  logic pend = 0;
  logic [33:0] pend_addr = 0;
  int nacc = 0;
  logic [33:0] seen [4];

  function automatic logic [31:0] rd(input logic [33:0] a);
    return pmem.exists(a) ? pmem[a] : 32'd0;
  endfunction

  function automatic logic [31:0] pte(input logic [21:0] ppn, input logic [7:0] fl);
    return {ppn, 2'b00, fl};
  endfunction

  always @(negedge clk) begin
    cyc++;
    mem_rsp_valid = 0;
    if (pend) begin
      mem_rsp_valid = 1; mem_rsp_data = rd(pend_addr); pend = 0;
    end
    mem_req_ready = (cyc % 3) != 1;
    if (mem_req_ready && mem_req_valid && rst_n) begin
      pend = 1; pend_addr = mem_req_addr;
      if (nacc < 4) seen[nacc] = mem_req_addr;
      nacc++;
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [33:0] act, exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic model(input logic [31:0] rt, va, input logic [1:0] k,
      output logic f, output logic [33:0] pa, output int na,
      output logic [33:0] a0, output logic [33:0] a1, output string tg);
    logic [31:0] e;
    logic pr;
    f = 0; pa = 0; a1 = 0; tg = "R7";
    a0 = {rt[21:0], va[31:22], 2'b00};
    if (!rt[31]) begin na = 0; pa = {2'b00, va}; tg = "R1"; return; end
    na = 1;
    e = rd(a0);
    pr = (k == 0) ? e[1] : (k == 1) ? e[2] : (k == 2) ? e[3] : 1'b0;
    if (!e[0]) begin f = 1; tg = "R3"; return; end
    if (e[2] && !e[1]) begin f = 1; tg = "R4"; return; end
    if (e[3:1] != 0) begin
      tg = "R8";
      if (!pr) begin f = 1; tg = "R6"; end
      else if (e[19:10] != 0) f = 1;
      else pa = {e[31:20], va[21:0]};
      return;
    end
    na = 2;
    a1 = {e[31:10], va[21:12], 2'b00};
    e = rd(a1);
    pr = (k == 0) ? e[1] : (k == 1) ? e[2] : (k == 2) ? e[3] : 1'b0;
    if (!e[0]) begin f = 1; tg = "R3"; return; end
    if (e[2] && !e[1]) begin f = 1; tg = "R4"; return; end
    if (e[3:1] == 0) begin f = 1; tg = "R5"; return; end
    if (!pr) begin f = 1; tg = "R6"; return; end
    pa = {e[31:10], va[11:0]};
  endtask

  task automatic walk(input logic [31:0] rt, va, input logic [1:0] k);
    logic ef; logic [33:0] ep, a0, a1; int na, t; string tg;
    model(rt, va, k, ef, ep, na, a0, a1, tg);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    nacc = 0;
    req_valid = 1; req_vaddr = va; req_kind = k; root = rt;
    @(negedge clk);
    req_valid = 0;
    t = 0;
    while (!rsp_valid && t < 100) begin @(negedge clk); t++; end
    if (!rsp_valid) begin chk(0, "watchdog", 0, 0); return; end
    chk(rsp_fault == ef, tg, {33'd0, rsp_fault}, {33'd0, ef});
    chk(rsp_paddr == ep, tg, rsp_paddr, ep);
    chk(nacc == na, "R2", nacc, na);
    if (na > 0) chk(seen[0] == a0, "R2", seen[0], a0);
    if (na > 1) chk(seen[1] == a1, "R2", seen[1], a1);
    @(negedge clk);
    chk(!rsp_valid, "R10", {33'd0, rsp_valid}, 0);
  endtask

  initial begin
    pmem[34'h100000] = pte(22'h200, 8'h01);
    for (int i = 0; i < 16; i++) pmem[34'h200000 + i*4] = pte(22'h3A000 + i, {4'h0, 4'(i)});
    pmem[34'h200000 + 16*4] = pte(22'h300, 8'h01);
    pmem[34'h100004] = pte({12'hABC, 10'h0}, 8'h0F);
    pmem[34'h100008] = pte({12'h123, 10'h5}, 8'h0F);
    pmem[34'h100010] = pte({12'h456, 10'h0}, 8'h03);
    pmem[34'h100014] = pte({12'h789, 10'h0}, 8'h05);
    pmem[34'h100018] = pte(22'h200, 8'h00);
    pmem[34'h10001C] = pte({12'hFFF, 10'h0}, 8'hCB);
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(req_ready === 1'b1, "R11", {33'd0, req_ready}, 1);
    chk(mem_req_valid === 1'b0, "R11", {33'd0, mem_req_valid}, 0);
    chk(rsp_valid === 1'b0, "R11", {33'd0, rsp_valid}, 0);
    rst_n = 1;
    // R1 bare mode
    for (int i = 0; i < 8; i++)
      walk({1'b0, 9'(i), 22'h100}, 32'hF000_0000 + i * 32'h1357_9BDF, 2'(i));
    // R3 R4 R5 R6 R7 R8 walk sweep, R2 address-space tag varied
    for (int l1 = 0; l1 < 8; l1++)
      for (int l2 = 0; l2 < 18; l2++)
        for (int k = 0; k < 4; k++)
          walk({1'b1, 9'(l2 * 7 + k), 22'h100},
               {10'(l1), 10'(l2), 12'((l1 * 37 + l2 * 101 + k * 13) & 12'hFFF)}, 2'(k));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #4000000;
    bad++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule